// File: doc/BRIEF.md
# Prioritized Wildcard Rule Table

This block classifies packet header keys against a small table of software-installed rules. Each rule carries a valid bit, a priority number, a value and a care-mask over the key bits, an action code with a port and a rewrite value, and its own packet and byte counters. A key and a packet length go in on the lookup port. Two cycles later the block reports whether any rule matched, and gives the action fields of the winning rule. That rule's counters are then bumped by one packet and by the packet's length.

The software port takes one command per cycle: install a rule at an index, remove a rule, or read a rule's counters back. Where patterns overlap, the priority field settles the winner, so traffic engineering, access control and default rules can share the one table. A rule whose mask is all zero matches every key. Given the lowest priority and a drop action, it serves as the default for unmatched traffic. Carrying out the actions on the packet is left to downstream logic.

Top module: `flow_rule_table`

## Requirements
- R1: A rule matches a key when it is valid and the key equals the rule value at every bit where the rule mask is 1; key bits under mask bits of 0 are ignored.
- R2: Among the valid rules that match, the one with the numerically largest priority wins.
- R3: When several matching rules share the largest priority, the one with the lowest index wins.
- R4: On a hit, resAction, resPort, resModVal and resIndex carry the winning rule's fields as installed. Action codes: 0 drop, 1 forward to resPort, 2 rewrite the destination field with resModVal and forward to resPort, 3 send to controller.
- R5: When no rule matches, resHit is 0, resAction is 0 (drop), resPort, resModVal and resIndex are 0, and no counter changes.
- R6: A lookup sampled with lkValid high at clock edge N drives resValid high for exactly the cycle after edge N+2. Lookups may be issued every cycle, and each yields one result in order.
- R7: On a hit, the winning rule's packet counter grows by 1 and its byte counter grows by lkLen.
- R8: A read command (swOp 2) sampled at edge N raises rdValid after edge N, with the packet and byte counts of rule swIndex. These counts include any lookup update committed to that rule at edge N.
- R9: An install command (swOp 0) writes priority, value, mask, action, port and rewrite value, marks the rule valid and clears both of its counters. When a counter update for the same rule falls on the same edge, the clear wins.
- R10: A remove command (swOp 1) stops the rule from matching. Its counters are kept and stay readable.
- R11: After reset every rule is invalid, every counter is zero, and resValid and rdValid are low.
- R12: A rule with an all-zero mask matches every key. At the lowest priority with action 0 it returns a hit with drop for traffic that no other rule takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkKey | input | KEY_W | Header key to classify |
| lkLen | input | LEN_W | Packet length in bytes |
| swValid | input | 1 | Software command strobe |
| swOp | input | 2 | 0 install, 1 remove, 2 read counters, 3 none |
| swIndex | input | IDX_W | Rule index for the command |
| swPri | input | PRI_W | Priority of an installed rule |
| swValue | input | KEY_W | Match value of an installed rule |
| swMask | input | KEY_W | Care-mask of an installed rule |
| swAction | input | 2 | Action code of an installed rule |
| swPort | input | PORT_W | Output port of an installed rule |
| swModVal | input | MOD_W | Rewrite value of an installed rule |
| resValid | output | 1 | Lookup result present |
| resHit | output | 1 | Some rule matched |
| resAction | output | 2 | Winning action code |
| resPort | output | PORT_W | Winning output port |
| resModVal | output | MOD_W | Winning rewrite value |
| resIndex | output | IDX_W | Index of the winning rule |
| rdValid | output | 1 | Counter read data present |
| rdPkts | output | PKT_W | Packet count read back |
| rdBytes | output | BYTE_W | Byte count read back |

## Verification
The bench builds overlapping prefix, suffix and catch-all rules. It then streams keys back to back that hit each of them, so a reversed priority compare or a wrong mask polarity shows up as the wrong resIndex. Two rules of equal priority are installed in both index orders to catch a tie broken toward the higher index. Counter reads are timed to land on the very edge where a lookup commits, which exposes a read that misses the in-flight update. A rule is reinstalled on the same edge, which exposes an install that lets the update win over the clear. A removed catch-all must turn hits into misses while keeping its old counts, and a miss must leave every counter untouched.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [1:0] {
    ACT_DROP    = 2'd0,
    ACT_FORWARD = 2'd1,
    ACT_REWRITE = 2'd2,
    ACT_PUNT    = 2'd3
  } action_e;

  typedef enum logic [1:0] {
    OP_INSTALL = 2'd0,
    OP_REMOVE  = 2'd1,
    OP_READ    = 2'd2,
    OP_NONE    = 2'd3
  } swop_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // latch the incoming key and length
    logic pick;     // latch the winning rule fields
    logic emit;     // a result leaves this cycle
    logic commit;   // the leaving result is a hit: bump counters
    logic install;  // write a rule
    logic remove;   // invalidate a rule
    logic readCnt;  // read counters back
  } strobe_t;

endpackage

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
#(
  parameter int N_RULES = 16,
  parameter int PRI_W   = 4,
  localparam int IDX_W  = $clog2(N_RULES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lkValid,
  input  logic                          swValid,
  input  logic [1:0]                    swOp,
  input  logic [N_RULES-1:0]            matchVec,
  input  logic [N_RULES-1:0][PRI_W-1:0] priArr,
  output strobe_t                       stb,
  output logic [IDX_W-1:0]              winSel,
  output logic [IDX_W-1:0]              commitIdx,
  output logic                          resValid,
  output logic                          resHit
);

  logic             v1, v2, hit2;
  logic [IDX_W-1:0] idx2;
  logic             anyMatch;
  logic [IDX_W-1:0] selC;
  logic [PRI_W-1:0] bestPri;

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    anyMatch = 1'b0;
    selC     = '0;
    bestPri  = '0;
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (matchVec[i] && (!anyMatch || priArr[i] >= bestPri)) begin
        anyMatch = 1'b1;
        bestPri  = priArr[i];
        selC     = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1       <= 1'b0;
      v2       <= 1'b0;
      hit2     <= 1'b0;
      idx2     <= '0;
      resValid <= 1'b0;
      resHit   <= 1'b0;
    end else begin
      v1 <= lkValid;
      v2 <= v1;
      if (v1) begin
        hit2 <= anyMatch;
        idx2 <= selC;
      end
      resValid <= v2;
      resHit   <= v2 && hit2;
    end
  end

  always_comb begin
    stb.capture = lkValid;
    stb.pick    = v1;
    stb.emit    = v2;
    stb.commit  = v2 && hit2;
    stb.install = swValid && (swOp == OP_INSTALL);
    stb.remove  = swValid && (swOp == OP_REMOVE);
    stb.readCnt = swValid && (swOp == OP_READ);
  end

  assign winSel    = selC;
  assign commitIdx = idx2;

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> ##3 resValid);  // R6
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> ##3 !resValid);  // R6
  AST_WINNER_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (v1 && (|matchVec)) |-> matchVec[winSel]);  // R1

  for (genvar g = 0; g < N_RULES; g++) begin : gChk
    AST_WINNER_HIGHEST: assert property (@(posedge clk) disable iff (!rstN)
      (v1 && matchVec[g]) |-> (priArr[g] <= priArr[winSel]));  // R2
    AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rstN)
      (v1 && matchVec[g] && priArr[g] == priArr[winSel]) |-> (winSel <= IDX_W'(g)));  // R3
  end

endmodule

// File: rtl/flow_dp.sv
module flow_dp
  import flow_pkg::*;
#(
  parameter int N_RULES = 16,
  parameter int KEY_W   = 32,
  parameter int PRI_W   = 4,
  parameter int PORT_W  = 4,
  parameter int MOD_W   = 16,
  parameter int LEN_W   = 16,
  parameter int PKT_W   = 32,
  parameter int BYTE_W  = 40,
  localparam int IDX_W  = $clog2(N_RULES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [KEY_W-1:0]              lkKey,
  input  logic [LEN_W-1:0]              lkLen,
  input  logic [IDX_W-1:0]              swIndex,
  input  logic [PRI_W-1:0]              swPri,
  input  logic [KEY_W-1:0]              swValue,
  input  logic [KEY_W-1:0]              swMask,
  input  logic [1:0]                    swAction,
  input  logic [PORT_W-1:0]             swPort,
  input  logic [MOD_W-1:0]              swModVal,
  input  logic [IDX_W-1:0]              winSel,
  input  logic [IDX_W-1:0]              commitIdx,
  output logic [N_RULES-1:0]            matchVec,
  output logic [N_RULES-1:0][PRI_W-1:0] priArr,
  output logic [1:0]                    resAction,
  output logic [PORT_W-1:0]             resPort,
  output logic [MOD_W-1:0]              resModVal,
  output logic [IDX_W-1:0]              resIndex,
  output logic                          rdValid,
  output logic [PKT_W-1:0]              rdPkts,
  output logic [BYTE_W-1:0]             rdBytes
);

  logic [N_RULES-1:0] ruleValid;
  logic [PRI_W-1:0]   rulePri  [N_RULES];
  logic [KEY_W-1:0]   ruleVal  [N_RULES];
  logic [KEY_W-1:0]   ruleMask [N_RULES];
  logic [1:0]         ruleAct  [N_RULES];
  logic [PORT_W-1:0]  rulePort [N_RULES];
  logic [MOD_W-1:0]   ruleMod  [N_RULES];
  logic [PKT_W-1:0]   pktCnt   [N_RULES];
  logic [BYTE_W-1:0]  byteCnt  [N_RULES];

  logic [KEY_W-1:0]   s1Key;
  logic [LEN_W-1:0]   s1Len, s2Len;
  logic [1:0]         s2Act;
  logic [PORT_W-1:0]  s2Port;
  logic [MOD_W-1:0]   s2Mod;
  logic               rdBump;

  for (genvar g = 0; g < N_RULES; g++) begin : gMatch
    assign matchVec[g] = ruleValid[g] && (((s1Key ^ ruleVal[g]) & ruleMask[g]) == '0);
    assign priArr[g]   = rulePri[g];
  end

  // rule storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ruleValid <= '0;
      for (int i = 0; i < N_RULES; i++) begin
        rulePri[i]  <= '0;
        ruleVal[i]  <= '0;
        ruleMask[i] <= '0;
        ruleAct[i]  <= ACT_DROP;
        rulePort[i] <= '0;
        ruleMod[i]  <= '0;
      end
    end else if (stb.install) begin
      ruleValid[swIndex] <= 1'b1;
      rulePri[swIndex]   <= swPri;
      ruleVal[swIndex]   <= swValue;
      ruleMask[swIndex]  <= swMask;
      ruleAct[swIndex]   <= swAction;
      rulePort[swIndex]  <= swPort;
      ruleMod[swIndex]   <= swModVal;
    end else if (stb.remove) begin
      ruleValid[swIndex] <= 1'b0;
    end
  end

  // lookup pipeline
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Key     <= '0;
      s1Len     <= '0;
      s2Len     <= '0;
      s2Act     <= ACT_DROP;
      s2Port    <= '0;
      s2Mod     <= '0;
      resAction <= ACT_DROP;
      resPort   <= '0;
      resModVal <= '0;
      resIndex  <= '0;
    end else begin
      if (stb.capture) begin
        s1Key <= lkKey;
        s1Len <= lkLen;
      end
      if (stb.pick) begin
        s2Len  <= s1Len;
        s2Act  <= ruleAct[winSel];
        s2Port <= rulePort[winSel];
        s2Mod  <= ruleMod[winSel];
      end
      if (stb.emit) begin
        if (stb.commit) begin
          resAction <= s2Act;
          resPort   <= s2Port;
          resModVal <= s2Mod;
          resIndex  <= commitIdx;
        end else begin
          resAction <= ACT_DROP;
          resPort   <= '0;
          resModVal <= '0;
          resIndex  <= '0;
        end
      end
    end
  end

  // counters: a same-edge install clears and beats the update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_RULES; i++) begin
        pktCnt[i]  <= '0;
        byteCnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_RULES; i++) begin
        if (stb.install && swIndex == IDX_W'(i)) begin
          pktCnt[i]  <= '0;
          byteCnt[i] <= '0;
        end else if (stb.commit && commitIdx == IDX_W'(i)) begin
          pktCnt[i]  <= pktCnt[i] + PKT_W'(1);
          byteCnt[i] <= byteCnt[i] + BYTE_W'(s2Len);
        end
      end
    end
  end

  // counter read with bypass of the update landing on the same edge
  assign rdBump = stb.commit && (commitIdx == swIndex);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdPkts  <= '0;
      rdBytes <= '0;
    end else begin
      rdValid <= stb.readCnt;
      if (stb.readCnt) begin
        rdPkts  <= pktCnt[swIndex] + (rdBump ? PKT_W'(1) : '0);
        rdBytes <= byteCnt[swIndex] + (rdBump ? BYTE_W'(s2Len) : '0);
      end
    end
  end

  for (genvar g = 0; g < N_RULES; g++) begin : gCntChk
    AST_INSTALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (stb.install && swIndex == IDX_W'(g)) |=> (pktCnt[g] == '0 && byteCnt[g] == '0));  // R9
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!(stb.commit && commitIdx == IDX_W'(g)) && !(stb.install && swIndex == IDX_W'(g)))
      |=> ($stable(pktCnt[g]) && $stable(byteCnt[g])));  // R5
  end

endmodule

// File: rtl/flow_rule_table.sv
module flow_rule_table
  import flow_pkg::*;
#(
  parameter int N_RULES = 16,
  parameter int KEY_W   = 32,
  parameter int PRI_W   = 4,
  parameter int PORT_W  = 4,
  parameter int MOD_W   = 16,
  parameter int LEN_W   = 16,
  parameter int PKT_W   = 32,
  parameter int BYTE_W  = 40,
  localparam int IDX_W  = $clog2(N_RULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [KEY_W-1:0]  lkKey,
  input  logic [LEN_W-1:0]  lkLen,
  input  logic              swValid,
  input  logic [1:0]        swOp,
  input  logic [IDX_W-1:0]  swIndex,
  input  logic [PRI_W-1:0]  swPri,
  input  logic [KEY_W-1:0]  swValue,
  input  logic [KEY_W-1:0]  swMask,
  input  logic [1:0]        swAction,
  input  logic [PORT_W-1:0] swPort,
  input  logic [MOD_W-1:0]  swModVal,
  output logic              resValid,
  output logic              resHit,
  output logic [1:0]        resAction,
  output logic [PORT_W-1:0] resPort,
  output logic [MOD_W-1:0]  resModVal,
  output logic [IDX_W-1:0]  resIndex,
  output logic              rdValid,
  output logic [PKT_W-1:0]  rdPkts,
  output logic [BYTE_W-1:0] rdBytes
);

  strobe_t                       stb;
  logic [N_RULES-1:0]            matchVec;
  logic [N_RULES-1:0][PRI_W-1:0] priArr;
  logic [IDX_W-1:0]              winSel, commitIdx;

  flow_ctrl #(.N_RULES(N_RULES), .PRI_W(PRI_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .swValid(swValid), .swOp(swOp),
    .matchVec(matchVec), .priArr(priArr), .stb(stb), .winSel(winSel),
    .commitIdx(commitIdx), .resValid(resValid), .resHit(resHit)
  );

  flow_dp #(
    .N_RULES(N_RULES), .KEY_W(KEY_W), .PRI_W(PRI_W), .PORT_W(PORT_W),
    .MOD_W(MOD_W), .LEN_W(LEN_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lkKey(lkKey), .lkLen(lkLen),
    .swIndex(swIndex), .swPri(swPri), .swValue(swValue), .swMask(swMask),
    .swAction(swAction), .swPort(swPort), .swModVal(swModVal),
    .winSel(winSel), .commitIdx(commitIdx), .matchVec(matchVec), .priArr(priArr),
    .resAction(resAction), .resPort(resPort), .resModVal(resModVal),
    .resIndex(resIndex), .rdValid(rdValid), .rdPkts(rdPkts), .rdBytes(rdBytes)
  );

  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resAction == ACT_DROP && resIndex == '0 && resPort == '0));  // R5
  AST_READ_CLEAN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(swValid));  // R8

endmodule

// File: tb/test_flow_rule_table.sv
`timescale 1ns/100ps
module test_flow_rule_table;

  localparam int N = 16;
  localparam real HALF = 2.5;

  typedef struct packed {
    logic        hit;
    logic [3:0]  idx;
    logic [1:0]  act;
    logic [3:0]  port;
    logic [15:0] mods;
    logic [7:0]  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkKey = '0;
  logic [15:0] lkLen = '0;
  logic        swValid = 1'b0;
  logic [1:0]  swOp = 2'd3;
  logic [3:0]  swIndex = '0;
  logic [3:0]  swPri = '0;
  logic [31:0] swValue = '0;
  logic [31:0] swMask = '0;
  logic [1:0]  swAction = '0;
  logic [3:0]  swPort = '0;
  logic [15:0] swModVal = '0;
  logic        resValid, resHit, rdValid;
  logic [1:0]  resAction;
  logic [3:0]  resPort, resIndex;
  logic [15:0] resModVal;
  logic [31:0] rdPkts;
  logic [39:0] rdBytes;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;
  exp_t expQ[$];

  // bench model of the table
  bit          mValid [N];
  logic [3:0]  mPri   [N];
  logic [31:0] mVal   [N];
  logic [31:0] mMask  [N];
  logic [1:0]  mAct   [N];
  logic [3:0]  mPort  [N];
  logic [15:0] mMod   [N];
  longint      mPkts  [N];
  longint      mBytes [N];

  always #(HALF) clk = ~clk;

  flow_rule_table i_flow_rule_table (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkKey(lkKey), .lkLen(lkLen),
    .swValid(swValid), .swOp(swOp), .swIndex(swIndex), .swPri(swPri),
    .swValue(swValue), .swMask(swMask), .swAction(swAction), .swPort(swPort),
    .swModVal(swModVal), .resValid(resValid), .resHit(resHit),
    .resAction(resAction), .resPort(resPort), .resModVal(resModVal),
    .resIndex(resIndex), .rdValid(rdValid), .rdPkts(rdPkts), .rdBytes(rdBytes)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint expv);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // winner: highest priority, earliest index on ties (ascending, strict >)
  function automatic void predict(input logic [31:0] key, output bit hit, output int idx);
    hit = 0;
    idx = 0;
    for (int i = 0; i < N; i++) begin
      if (mValid[i] && ((key & mMask[i]) == (mVal[i] & mMask[i]))) begin
        if (!hit || mPri[i] > mPri[idx]) begin
          hit = 1;
          idx = i;
        end
      end
    end
  endfunction

  task automatic quiet();
    @(negedge clk);
    lkValid = 1'b0;
    swValid = 1'b0;
    swOp    = 2'd3;
  endtask

  task automatic lookup(input logic [31:0] key, input logic [15:0] len, input int req);
    bit   h;
    int   w;
    exp_t e;
    @(negedge clk);
    swValid = 1'b0;
    swOp    = 2'd3;
    lkValid = 1'b1;
    lkKey   = key;
    lkLen   = len;
    predict(key, h, w);
    e.hit  = h;
    e.idx  = h ? 4'(w) : 4'd0;
    e.act  = h ? mAct[w] : 2'd0;
    e.port = h ? mPort[w] : 4'd0;
    e.mods = h ? mMod[w] : 16'd0;
    e.req  = 8'(req);
    expQ.push_back(e);
    if (h) begin
      mPkts[w]  = mPkts[w] + 1;
      mBytes[w] = mBytes[w] + longint'(len);
    end
  endtask

  task automatic install(input int idx, input logic [3:0] pri, input logic [31:0] val,
                         input logic [31:0] msk, input logic [1:0] act,
                         input logic [3:0] port, input logic [15:0] mods);
    @(negedge clk);
    lkValid  = 1'b0;
    swValid  = 1'b1;
    swOp     = 2'd0;
    swIndex  = 4'(idx);
    swPri    = pri;
    swValue  = val;
    swMask   = msk;
    swAction = act;
    swPort   = port;
    swModVal = mods;
    mValid[idx] = 1;
    mPri[idx]   = pri;
    mVal[idx]   = val;
    mMask[idx]  = msk;
    mAct[idx]   = act;
    mPort[idx]  = port;
    mMod[idx]   = mods;
    mPkts[idx]  = 0;
    mBytes[idx] = 0;
  endtask

  task automatic removeRule(input int idx);
    @(negedge clk);
    lkValid = 1'b0;
    swValid = 1'b1;
    swOp    = 2'd1;
    swIndex = 4'(idx);
    mValid[idx] = 0;
  endtask

  task automatic readChk(input int idx, input int req);
    @(negedge clk);
    lkValid = 1'b0;
    swValid = 1'b1;
    swOp    = 2'd2;
    swIndex = 4'(idx);
    @(negedge clk);
    swValid = 1'b0;
    swOp    = 2'd3;
    chk(rdValid == 1'b1, req, "rdValid", longint'(rdValid), 1);
    chk(longint'(rdPkts) == mPkts[idx], req, $sformatf("pkts rule %0d", idx),
        longint'(rdPkts), mPkts[idx]);
    chk(longint'(rdBytes) == mBytes[idx], req, $sformatf("bytes rule %0d", idx),
        longint'(rdBytes), mBytes[idx]);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        chk(0, 6, "unexpected result", 1, 0);  // R6
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(resHit == e.hit, int'(e.req), "resHit", longint'(resHit), longint'(e.hit));
        chk(resAction == e.act, int'(e.req), "resAction", longint'(resAction), longint'(e.act));
        chk(resPort == e.port, int'(e.req), "resPort", longint'(resPort), longint'(e.port));
        chk(resModVal == e.mods, int'(e.req), "resModVal", longint'(resModVal), longint'(e.mods));
        chk(resIndex == e.idx, int'(e.req), "resIndex", longint'(resIndex), longint'(e.idx));
      end
    end
  end

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mPri[i] = 0; mVal[i] = 0; mMask[i] = 0;
      mAct[i] = 0; mPort[i] = 0; mMod[i] = 0; mPkts[i] = 0; mBytes[i] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(resValid == 1'b0, 11, "resValid after reset", longint'(resValid), 0);
    chk(rdValid == 1'b0, 11, "rdValid after reset", longint'(rdValid), 0);
    readChk(0, 11);      // R11 counters zero
    lookup(32'h0A00_1234, 16'd64, 5);  // R5 empty table: miss
    quiet();
    repeat (3) quiet();

    // rule set: prefix, suffix, low byte, catch-all
    install(2, 4'd3, 32'h0A00_0000, 32'hFFFF_0000, 2'd1, 4'd1, 16'h0000);
    install(7, 4'd2, 32'h0000_0050, 32'h0000_FFFF, 2'd2, 4'd2, 16'hBEEF);
    install(9, 4'd1, 32'h0000_0019, 32'h0000_00FF, 2'd3, 4'd0, 16'h0000);
    install(15, 4'd0, 32'h1234_5678, 32'h0000_0000, 2'd0, 4'd0, 16'h0000);
    // back-to-back stream (R6)
    lookup(32'h0A00_1234, 16'd64, 1);    // R1 prefix hit rule 2
    lookup(32'h0A00_0050, 16'd1500, 2);  // R2 rule 2 beats rule 7 and 15
    lookup(32'h0B00_0050, 16'd100, 4);   // R4 rewrite action from rule 7
    lookup(32'h0B00_0019, 16'd40, 4);    // R4 send to controller via rule 9
    lookup(32'hC000_0001, 16'd77, 12);   // R12 catch-all drop hit
    quiet();
    readChk(15, 7);   // R7 lands on the commit edge of the last lookup (R8 bypass)
    readChk(2, 7);    // R7 two packets, 1564 bytes
    readChk(7, 8);    // R8

    // ties (R3)
    install(4, 4'd3, 32'h0A00_0000, 32'hFF00_0000, 2'd3, 4'd5, 16'h0000);
    lookup(32'h0A00_AAAA, 16'd10, 3);    // R3 rule 2 over rule 4
    install(1, 4'd3, 32'h0A00_0000, 32'hFF00_0000, 2'd1, 4'd9, 16'h0000);
    lookup(32'h0A00_AAAA, 16'd11, 3);    // R3 rule 1 now wins
    quiet();
    repeat (3) quiet();

    // remove (R10) and miss leaves counters (R5)
    removeRule(15);
    lookup(32'hC000_0001, 16'd99, 10);   // R10 removed catch-all: miss
    quiet();
    repeat (3) quiet();
    readChk(15, 10);  // R10 counters retained
    for (int i = 0; i < N; i++) begin
      if (i != 15) readChk(i, 5);  // R5 miss touched nothing
    end

    // install on the commit edge (R9)
    lookup(32'h0B00_0050, 16'd300, 4);   // R4 rule 7 still rewrite
    quiet();
    install(7, 4'd5, 32'h0B00_0000, 32'hFF00_0000, 2'd1, 4'd3, 16'h0000);
    quiet();
    readChk(7, 9);    // R9 clear beat the update
    lookup(32'h0B00_00FF, 16'd50, 9);    // R9 new rule 7 fields
    quiet();
    repeat (3) quiet();
    readChk(7, 9);

    // exact latency (R6)
    lookup(32'h0B00_0019, 16'd20, 6);
    quiet();
    chk(resValid == 1'b0, 6, "resValid at N", longint'(resValid), 0);
    @(negedge clk);
    chk(resValid == 1'b0, 6, "resValid at N+1", longint'(resValid), 0);
    @(negedge clk);
    chk(resValid == 1'b1, 6, "resValid at N+2", longint'(resValid), 1);
    repeat (4) quiet();
    chk(expQ.size() == 0, 6, "results outstanding", longint'(expQ.size()), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule